// File: doc/BRIEF.md
# Nested Weighted Memory-Bus Arbiter

This block decides which of nine requesters owns a shared memory bus for the next transaction. The requesters are a CPU, a video output engine, an image coprocessor, a video input engine, a PCI bridge, a variable-length decoder, an audio output engine, an audio input engine and a spare slot. Their request bits are indexed in that order, 0 to 8. The arbitration structure is a chain of five two-way levels. Level k sets requester k against everything below it. The bottom of the chain is a fixed-weight rotation over the last four requesters. Programmable weights at each level set the share of grants each side receives when the bus is saturated. When the bus is lightly loaded, any requester that is alone is served at once. Because the CPU sits at the head of the chain, it receives all bandwidth that the others leave unused.

Four requesters can have a priority-raise delay: video out, video in, PCI and the decoder. Once one of them has waited long enough, it jumps ahead of the weighted ordering.

The interface uses plain request/grant lines.
- A requester holds its request until it has been granted.
- The memory controller pulses `done_i` for one cycle when the current transaction ends.
- The grant is registered and stays on for the whole transaction. That held grant is the only back-pressure the block applies.

Top module: `bus_arb`

## Requirements
- R1: After reset, no grant is asserted, all level consumption counters are cleared, every level starts on its first (single-requester) side, and all wait counters are zero.
- R2: `gnt_o` is one-hot or zero. A new decision is taken only on a clock edge where the bus is idle or `done_i` is high; otherwise the grant holds unchanged. A `done_i` pulse while idle with no request leaves the grant at zero.
- R3: A requester that is the only one requesting is granted at the next decision. A decision with no request pending drops the grant to zero.
- R4: At a two-way level with weights A (bits [8k+3:8k] of `lvl_wgt_i`) and B (bits [8k+7:8k+4]), both non-zero and both sides requesting, the first side wins up to A consecutive decisions through that level, then the second side up to B. Example: A=2, B=1 gives CPU, CPU, video out, repeating.
- R5: A side whose weight is zero is served at that level only while the other side is not requesting.
- R6: Level k (k = 0 to 4) sets requester k against the OR of requesters k+1 to 8. Requesters 5 to 8 form the bottom level.
- R7: The bottom level rotates in index order 5, 6, 7, 8 with fixed weights 2, 1, 1, 0. The zero-weight spare slot (index 8) is served only when no other bottom requester is pending.
- R8: A raise-capable requester with delay R ≠ 0 that has been requesting without a grant for at least 16×R cycles is granted at the next decision, ahead of the weighted ordering. The delay field for slot s is `raise_dly_i[6s+5:6s]`, where slot 0 = video out, 1 = video in, 2 = PCI, 3 = decoder. R = 0 disables raising.
- R9: Raised requesters are served in the fixed order video out, video in, PCI, decoder. A requester's wait counter clears when it is granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 9 | Request per requester, index order as listed above |
| done_i | input | 1 | One-cycle strobe from the memory controller marking the end of the current transaction |
| lvl_wgt_i | input | 40 | Five levels of 8 bits each: low nibble is the single-side weight, high nibble is the lower-chain weight |
| raise_dly_i | input | 24 | Four 6-bit priority-raise delays, counted in units of 16 cycles |
| gnt_o | output | 9 | One-hot grant, held for the whole transaction |

## Verification
Every grant is registered. A decision taken at a rising edge, either from the idle state or on a `done_i` pulse, shows on `gnt_o` right after that edge. The bench changes requests and strobes on the falling edge and reads the grant one falling edge later, exactly one register stage after the stimulus. Raise thresholds are exercised with wait windows far from the 16×R boundary (3 cycles against 20), so a one-cycle offset in the wait counter cannot flip an expected result. Sequences of several decisions are read one grant per `done_i` pulse, so each position in a weighted or rotating pattern is compared on its own.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int NREQ  = 9;   // requesters
  localparam int NLVL  = 5;   // two-way levels in the chain
  localparam int NBOT  = 4;   // slots in the bottom rotation
  localparam int WW    = 4;   // weight width
  localparam int RW    = 6;   // raise delay width
  localparam int NRS   = 4;   // raise-capable requesters
  localparam int PRE   = 4;   // raise delay unit is 2**PRE cycles

  // Bottom weights, slot 0 in the low nibble: 2,1,1,0
  localparam logic [NBOT*WW-1:0] BOT_WGT = {4'd0, 4'd1, 4'd1, 4'd2};

  // Raise slot to requester index (video out, video in, PCI, decoder)
  function automatic int raise_idx(input int s);
    case (s)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/arb_pair_level.sv
module arb_pair_level #(
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_a,
  input  logic          req_b,
  input  logic [WW-1:0] w_a,
  input  logic [WW-1:0] w_b,
  input  logic          upd,
  output logic          pick_a,
  output logic          pick_b
);
  localparam logic [WW-1:0] ONE = {{(WW-1){1'b0}}, 1'b1};

  logic          on_b;   // side currently holding the turn
  logic [WW-1:0] used;   // consecutive wins of that side

  always_comb begin
    pick_a = 1'b0;
    pick_b = 1'b0;
    if (req_a && !req_b)       pick_a = 1'b1;
    else if (!req_a && req_b)  pick_b = 1'b1;
    else if (req_a && req_b) begin
      if (w_a == '0 && w_b != '0) pick_b = 1'b1;
      else if (w_b == '0)         pick_a = 1'b1;
      else if (!on_b) begin
        if (used < w_a) pick_a = 1'b1;
        else            pick_b = 1'b1;
      end else begin
        if (used < w_b) pick_b = 1'b1;
        else            pick_a = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_b <= 1'b0;
      used <= '0;
    end else if (upd && (pick_a || pick_b)) begin
      if (pick_b == on_b) begin
        if (used != '1) used <= used + ONE;
      end else begin
        on_b <= pick_b;
        used <= ONE;
      end
    end
  end
endmodule

// File: rtl/arb_bottom_wrr.sv
module arb_bottom_wrr #(
  parameter int                N   = 4,
  parameter int                WW  = 4,
  parameter logic [N*WW-1:0]   WGT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         upd,
  output logic [N-1:0] pick
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [WW-1:0] ONE = {{(WW-1){1'b0}}, 1'b1};

  logic [PW-1:0] ptr;
  logic [WW-1:0] used;
  logic [PW-1:0] pidx;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    // rotate from the current slot; the current slot needs credit left
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = (int'(ptr) + off) % N;
      if (!found && req[idx] && WGT[idx*WW +: WW] != '0 &&
          (off != 0 || used < WGT[idx*WW +: WW])) begin
        pick[idx] = 1'b1;
        found     = 1'b1;
      end
    end
    // current slot alone keeps the bus even when its credit is spent
    if (!found && req[ptr] && WGT[int'(ptr)*WW +: WW] != '0) begin
      pick[ptr] = 1'b1;
      found     = 1'b1;
    end
    // zero-weight slots only when nothing weighted is pending
    for (int i = 0; i < N; i++) begin
      if (!found && req[i] && WGT[i*WW +: WW] == '0) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    pidx = '0;
    for (int i = 0; i < N; i++)
      if (pick[i]) pidx = PW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      used <= '0;
    end else if (upd && (|pick)) begin
      if (pidx == ptr) begin
        if (used != '1) used <= used + ONE;
      end else begin
        ptr  <= pidx;
        used <= ONE;
      end
    end
  end
endmodule

// File: rtl/arb_raise_ctr.sv
module arb_raise_ctr #(
  parameter int RW  = 6,
  parameter int PRE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          granted,
  input  logic [RW-1:0] dly,
  output logic          raised
);
  localparam int CW = RW + PRE;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              wait_cnt <= '0;
    else if (granted || !req) wait_cnt <= '0;
    else if (wait_cnt != '1) wait_cnt <= wait_cnt + ONE;
  end

  assign raised = req && (dly != '0) && (wait_cnt >= {dly, {PRE{1'b0}}});
endmodule

// File: rtl/bus_arb.sv
module bus_arb
  import bus_arb_pkg::*;
#(
  parameter int                   P_NREQ = NREQ,
  parameter int                   P_NLVL = NLVL,
  parameter int                   P_NBOT = NBOT,
  parameter int                   P_WW   = WW,
  parameter int                   P_RW   = RW,
  parameter int                   P_NRS  = NRS,
  parameter logic [NBOT*WW-1:0]   P_BOT  = BOT_WGT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [P_NREQ-1:0]          req_i,
  input  logic                       done_i,
  input  logic [P_NLVL*2*P_WW-1:0]   lvl_wgt_i,
  input  logic [P_NRS*P_RW-1:0]      raise_dly_i,
  output logic [P_NREQ-1:0]          gnt_o
);
  localparam int LW = 2 * P_WW;

  logic [P_NREQ-1:0] gnt_q;
  logic [P_NLVL-1:0] pick_a, pick_b, lvl_upd;
  logic [P_NBOT-1:0] bot_pick;
  logic              bot_upd;
  logic [P_NRS-1:0]  raised;
  logic [P_NREQ-1:0] w_win, r_win, nxt;
  logic              decide, use_raise;

  // chain of two-way levels: requester k against everything below
  for (genvar k = 0; k < P_NLVL; k++) begin : g_lvl
    arb_pair_level #(.WW(P_WW)) u_lvl (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_a  (req_i[k]),
      .req_b  (|req_i[P_NREQ-1:k+1]),
      .w_a    (lvl_wgt_i[k*LW +: P_WW]),
      .w_b    (lvl_wgt_i[k*LW+P_WW +: P_WW]),
      .upd    (lvl_upd[k]),
      .pick_a (pick_a[k]),
      .pick_b (pick_b[k])
    );
  end

  arb_bottom_wrr #(.N(P_NBOT), .WW(P_WW), .WGT(P_BOT)) u_bot (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i[P_NREQ-1:P_NLVL]),
    .upd   (bot_upd),
    .pick  (bot_pick)
  );

  for (genvar s = 0; s < P_NRS; s++) begin : g_raise
    localparam int RI = raise_idx(s);
    arb_raise_ctr #(.RW(P_RW), .PRE(PRE)) u_rc (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_i[RI]),
      .granted (gnt_q[RI] | (decide & nxt[RI])),
      .dly     (raise_dly_i[s*P_RW +: P_RW]),
      .raised  (raised[s])
    );
  end

  always_comb begin
    logic stop, rstop;
    decide = !(|gnt_q) || done_i;

    // walk the chain down to the first level that keeps its single side
    w_win = '0;
    stop  = 1'b0;
    for (int k = 0; k < P_NLVL; k++) begin
      if (!stop) begin
        if (pick_a[k]) begin
          w_win[k] = 1'b1;
          stop     = 1'b1;
        end else if (!pick_b[k]) begin
          stop = 1'b1;
        end
      end
    end
    if (!stop) w_win[P_NREQ-1:P_NLVL] = bot_pick;

    // raised requesters override, fixed order
    r_win = '0;
    rstop = 1'b0;
    for (int s = 0; s < P_NRS; s++) begin
      if (!rstop && raised[s]) begin
        r_win[raise_idx(s)] = 1'b1;
        rstop = 1'b1;
      end
    end
    use_raise = rstop;
    nxt       = use_raise ? r_win : w_win;

    for (int k = 0; k < P_NLVL; k++)
      lvl_upd[k] = decide && !use_raise && (|(w_win >> k));
    bot_upd = decide && !use_raise && (|w_win[P_NREQ-1:P_NLVL]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gnt_q <= '0;
    else if (decide) gnt_q <= nxt;
  end

  assign gnt_o = gnt_q;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk #(
  parameter int NREQ = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NREQ-1:0] req_i,
  input logic            done_i,
  input logic [NREQ-1:0] gnt_o
);
  // R2: never more than one owner
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R2: grant holds through a transaction until done
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gnt_o) && !done_i) |=> $stable(gnt_o));

  // R2: a new owner was requesting at the decision
  a_r2_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gnt_o & ~$past(gnt_o))) |-> (|($past(req_i) & gnt_o)));

  // R3: no request at a decision leaves the bus free
  a_r3_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((!(|gnt_o) || done_i) && !(|req_i)) |=> !(|gnt_o));

  // R3: lone CPU request is served at the decision
  a_r3_lone_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    ((!(|gnt_o) || done_i) && req_i == NREQ'(1)) |=> gnt_o == NREQ'(1));
endmodule

bind bus_arb bus_arb_chk #(.NREQ(P_NREQ)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .done_i (done_i),
  .gnt_o  (gnt_o)
);

// File: tb/sim_bus_arb.sv
module sim_bus_arb;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] G_CPU = 9'h001, G_VOUT = 9'h002, G_ICP = 9'h004,
                         G_VIN = 9'h008, G_PCI = 9'h010, G_DEC = 9'h020,
                         G_AOUT = 9'h040, G_AIN = 9'h080, G_SPR = 9'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  req = '0;
  logic        done = 1'b0;
  logic [39:0] lvl_wgt = '0;
  logic [23:0] raise_dly = '0;
  logic [8:0]  gnt;
  int n_cmp = 0, n_err = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_arb u0 (.clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
              .lvl_wgt_i(lvl_wgt), .raise_dly_i(raise_dly), .gnt_o(gnt));

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: gnt=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic set_lvl(input int k, input logic [3:0] a, input logic [3:0] b);
    lvl_wgt[k*8 +: 4]   = a;
    lvl_wgt[k*8+4 +: 4] = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; done = 1'b0;
    for (int k = 0; k < 5; k++) set_lvl(k, 4'd1, 4'd1);
    raise_dly = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // request from idle, grant visible one edge later
  task automatic start(input logic [8:0] r);
    @(negedge clk); req = r;
    @(negedge clk);
  endtask

  // end the transaction with new requests, read the next grant
  task automatic pulse_done(input logic [8:0] r);
    @(negedge clk); req = r; done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 reset grant", gnt, '0);
  endtask

  task automatic t_lone_hold();
    do_reset();
    start(G_VOUT);
    chk("R3 lone requester", gnt, G_VOUT);
    @(negedge clk); req = G_VOUT | G_CPU;
    repeat (5) @(negedge clk);
    chk("R2 hold during transaction", gnt, G_VOUT);
    pulse_done(G_CPU);
    chk("R2 next after done", gnt, G_CPU);
    pulse_done('0);
    chk("R3 no request drops grant", gnt, '0);
    pulse_done('0);
    chk("R2 done while idle", gnt, '0);
  endtask

  task automatic t_weighted();
    logic [8:0] exp [6] = '{G_CPU, G_CPU, G_VOUT, G_CPU, G_CPU, G_VOUT};
    do_reset();
    set_lvl(0, 4'd2, 4'd1);
    start(G_CPU | G_VOUT);
    chk("R4 weighted 0", gnt, exp[0]);
    for (int i = 1; i < 6; i++) begin
      pulse_done(G_CPU | G_VOUT);
      chk($sformatf("R4 weighted %0d", i), gnt, exp[i]);
    end
  endtask

  task automatic t_zero();
    do_reset();
    set_lvl(0, 4'd3, 4'd0);
    start(G_CPU | G_PCI);
    chk("R5 zero weight 0", gnt, G_CPU);
    for (int i = 1; i < 5; i++) begin
      pulse_done(G_CPU | G_PCI);
      chk($sformatf("R5 zero weight %0d", i), gnt, G_CPU);
    end
    pulse_done(G_PCI);
    chk("R5 zero side alone", gnt, G_PCI);
  endtask

  task automatic t_chain();
    do_reset();
    start(G_ICP | G_VIN);
    chk("R6 chain 0", gnt, G_ICP);
    pulse_done(G_ICP | G_VIN);
    chk("R6 chain 1", gnt, G_VIN);
    pulse_done(G_ICP | G_VIN);
    chk("R6 chain 2", gnt, G_ICP);
  endtask

  task automatic t_bottom();
    logic [8:0] exp [6] = '{G_DEC, G_DEC, G_AOUT, G_AIN, G_DEC, G_DEC};
    logic [8:0] bot = G_DEC | G_AOUT | G_AIN;
    do_reset();
    start(bot);
    chk("R7 bottom 0", gnt, exp[0]);
    for (int i = 1; i < 6; i++) begin
      pulse_done(bot);
      chk($sformatf("R7 bottom %0d", i), gnt, exp[i]);
    end
    do_reset();
    start(G_AOUT | G_SPR);
    chk("R7 spare starved 0", gnt, G_AOUT);
    for (int i = 1; i < 3; i++) begin
      pulse_done(G_AOUT | G_SPR);
      chk("R7 spare starved", gnt, G_AOUT);
    end
    pulse_done(G_SPR);
    chk("R7 spare alone", gnt, G_SPR);
  endtask

  task automatic t_raise();
    do_reset();
    set_lvl(0, 4'd4, 4'd0);
    raise_dly[1*6 +: 6] = 6'd1;   // video in, 16 cycles
    start(G_CPU | G_VOUT | G_VIN);
    chk("R8 first grant", gnt, G_CPU);
    repeat (3) @(negedge clk);
    pulse_done(G_CPU | G_VOUT | G_VIN);
    chk("R8 before threshold", gnt, G_CPU);
    repeat (20) @(negedge clk);
    pulse_done(G_CPU | G_VOUT | G_VIN);
    chk("R8 raised wins", gnt, G_VIN);
    pulse_done(G_CPU | G_VOUT);
    chk("R8 back to weights", gnt, G_CPU);
    repeat (20) @(negedge clk);
    pulse_done(G_CPU | G_VOUT);
    chk("R8 zero delay never raises", gnt, G_CPU);
  endtask

  task automatic t_order();
    logic [8:0] all = G_CPU | G_VOUT | G_VIN;
    do_reset();
    set_lvl(0, 4'd4, 4'd0);
    raise_dly[0*6 +: 6] = 6'd1;
    raise_dly[1*6 +: 6] = 6'd1;
    start(all);
    chk("R9 first grant", gnt, G_CPU);
    repeat (20) @(negedge clk);
    pulse_done(all);
    chk("R9 video out first", gnt, G_VOUT);
    pulse_done(all);
    chk("R9 video in second", gnt, G_VIN);
    pulse_done(all);
    chk("R9 counters cleared", gnt, G_CPU);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_lone_hold();
    t_weighted();
    t_zero();
    t_chain();
    t_bottom();
    t_raise();
    t_order();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end
endmodule